// File: doc/BRIEF.md
# Vectored nested interrupt controller

This block gathers up to 128 interrupt sources onto one processor interrupt line. Each source has a priority, a trigger type and a vector word. Software reaches these per-source settings through a small window. It first writes a source number into a select register. It then reads or writes the mode and vector registers, or writes the enable, disable, clear and set commands. Every one of these acts on the selected source only.

When the processor takes the interrupt, it reads the interrupt-vector register. That read is the acknowledge. It returns the vector of the winning source, pushes that source's priority and number onto an eight-level nesting stack, and drops any latched request of that source. While a priority sits on the stack, only a strictly higher priority can raise the line again. An end-of-interrupt write pops one level. If nothing can win at the moment of the read, the read returns a programmable spurious vector and the stack is left alone.

The register bus is a plain single-cycle port with no back-pressure. A write takes effect at the clock edge where `bus_en_i` and `bus_we_i` are high. A read is accepted at the edge where `bus_en_i` is high and `bus_we_i` is low. Its data appears on `bus_rdata_o` after that edge and holds until the next read.

Top module: `vnic_ctrl`

## Requirements
- R1: A write to offset 0x00 stores bits [SEL_W-1:0] of the write data as the selected source, and a read of 0x00 returns it. A value of NUM_SRC or more is ignored and leaves the previous selection in place.
- R2: Offset 0x04 is the mode of the selected source. The priority is in bits [2:0] and the trigger type in bits [6:5]: 00 level-high, 01 rising edge, 10 level-low, 11 falling edge. A read returns these fields with all other bits zero.
- R3: Offset 0x08 holds the vector word of the selected source and reads back what was written. Offset 0x3C holds the spurious vector.
- R4: The enable command (write to 0x40) and the disable command (write to 0x44) set or clear the enable of the selected source only. A read of 0x30 returns 32 enable bits of bank sel/32, where bit i is source bank*32+i and bits beyond NUM_SRC read zero.
- R5: A level-high source is pending in the same cycle its input is 1, and a level-low source in the same cycle its input is 0. Neither latches the level.
- R6: On a rising edge (rising mode) or a falling edge (falling mode) of the input, the source becomes pending from the next cycle. It stays pending until it is acknowledged or cleared.
- R7: The set command (write to 0x4C) latches a request on the selected source in any trigger mode. The clear command (write to 0x48) removes the latched request. Neither command touches any other source.
- R8: Among the sources that are pending and enabled, the winner has the highest priority. Ties go to the lower source number.
- R9: `irq_o` is high in the same cycle a winner exists and either the stack is empty or the winner's priority is strictly greater than the priority on top of the stack.
- R10: A read of 0x10 while `irq_o` is high returns the winner's vector, pushes its priority and number, and drops its latched request. A read of 0x18 returns the number of the source on top of the stack, or 0 when the stack is empty.
- R11: A read of 0x10 while `irq_o` is low returns the spurious vector and leaves the stack unchanged.
- R12: A write to 0x38 pops one stack level and has no effect on an empty stack. Eight such writes unwind a full eight-level stack and release `irq_o`.
- R13: After reset the select, modes, vectors, spurious vector, enables, latched requests and read data are zero, the stack is empty and `irq_o` is low. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid after the read edge |
| irq_o | output | 1 | Processor interrupt request |

## Verification
The bench builds the controller with NUM_SRC set to 40, so the select field is six bits wide. With that value the select range check rejects numbers from 40 to 63, and the second enable bank is only partly populated. Priority width, vector width and nesting depth keep their defaults. That lets the bench walk the stack through all eight priority levels to full depth, then unwind it with one extra end-of-interrupt write on an empty stack.

// File: rtl/vnic_pkg.sv
package vnic_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_SEL  = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_VEC  = 8'h08;
  localparam logic [7:0] OFS_IVR  = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h18;
  localparam logic [7:0] OFS_MASK = 8'h30;
  localparam logic [7:0] OFS_EOI  = 8'h38;
  localparam logic [7:0] OFS_SPUR = 8'h3C;
  localparam logic [7:0] OFS_EN   = 8'h40;
  localparam logic [7:0] OFS_DIS  = 8'h44;
  localparam logic [7:0] OFS_CLR  = 8'h48;
  localparam logic [7:0] OFS_SET  = 8'h4C;

  // mode word layout
  localparam int MODE_TRIG_LSB = 5;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/vnic_src_cell.sv
module vnic_src_cell
  import vnic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_i,
  input  logic [1:0] trig_i,
  input  logic       set_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic prev_q;
  logic latch_q;
  logic level_hit;
  logic edge_hit;

  always_comb begin
    level_hit = 1'b0;
    edge_hit  = 1'b0;
    case (trig_i)
      TRIG_HIGH: level_hit = src_i;
      TRIG_LOW:  level_hit = ~src_i;
      TRIG_RISE: edge_hit  = src_i & ~prev_q;
      default:   edge_hit  = ~src_i & prev_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= src_i;
      // a fresh edge or set outranks a clear in the same cycle
      latch_q <= (latch_q & ~clr_i) | edge_hit | set_i;
    end
  end

  assign pend_o = level_hit | latch_q;
endmodule

// File: rtl/vnic_arbiter.sv
module vnic_arbiter #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 3,
  parameter int IDX_W   = 7
) (
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vnic_nest_stack.sv
module vnic_nest_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 7,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic [IDX_W-1:0]  push_idx_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic [IDX_W-1:0]  top_idx_o
);
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [IDX_W-1:0]  idx_q  [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  top_ptr;
  logic [PTR_W-1:0]  wr_ptr;
  logic              full;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_ptr = PTR_W'(cnt_q - CNT_W'(1));
  assign wr_ptr  = PTR_W'(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_q[i] <= '0;
        idx_q[i]  <= '0;
      end
    end else if (push_i && !full) begin
      prio_q[wr_ptr] <= push_prio_i;
      idx_q[wr_ptr]  <= push_idx_i;
      cnt_q          <= cnt_q + CNT_W'(1);
    end else if (pop_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign count_o    = cnt_q;
  assign top_prio_o = (cnt_q != '0) ? prio_q[top_ptr] : '0;
  assign top_idx_o  = (cnt_q != '0) ? idx_q[top_ptr]  : '0;
endmodule

// File: rtl/vnic_ctrl.sv
module vnic_ctrl
  import vnic_pkg::*;
#(
  parameter int NUM_SRC    = 128,
  parameter int PRIO_W     = 3,   // at most 5, mode bits [6:5] hold the trigger
  parameter int VEC_W      = 32,
  parameter int NEST_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [7:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int BANKS = (NUM_SRC + 31) / 32;
  localparam int CNT_W = $clog2(NEST_DEPTH + 1);
  localparam logic [SEL_W:0] SRC_LIM = (SEL_W + 1)'(NUM_SRC);

  // per-source configuration
  logic [SEL_W-1:0]  sel_q;
  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  logic [1:0]        trig_q [NUM_SRC];
  logic [VEC_W-1:0]  vec_q  [NUM_SRC];
  logic [NUM_SRC-1:0] en_q;
  logic [VEC_W-1:0]  spur_q;
  logic [31:0]       rdata_q;

  logic wr, rd;
  logic [NUM_SRC-1:0]        sel_hot;
  logic [NUM_SRC-1:0]        set_mask;
  logic [NUM_SRC-1:0]        clr_mask;
  logic [NUM_SRC-1:0]        pend;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  logic              arb_valid;
  logic [SEL_W-1:0]  arb_idx;
  logic [PRIO_W-1:0] arb_prio;

  logic              push, pop, ack;
  logic [CNT_W-1:0]  stk_cnt;
  logic [PRIO_W-1:0] top_prio;
  logic [SEL_W-1:0]  top_idx;

  logic [BANKS*32-1:0] en_pad;
  logic [31:0]         rd_val;
  logic [31:0]         mode_word;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata_i;

  assign wr      = bus_en_i & bus_we_i;
  assign rd      = bus_en_i & ~bus_we_i;
  assign sel_hot = NUM_SRC'(1) << sel_q;

  // arbitration and line
  assign irq_o = arb_valid && (stk_cnt == '0 || arb_prio > top_prio);
  assign ack   = rd && bus_addr_i == OFS_IVR && irq_o;
  assign push  = ack;
  assign pop   = wr && bus_addr_i == OFS_EOI;

  assign set_mask = (wr && bus_addr_i == OFS_SET) ? sel_hot : '0;
  assign clr_mask = ((wr && bus_addr_i == OFS_CLR) ? sel_hot : '0)
                  | (ack ? (NUM_SRC'(1) << arb_idx) : '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
    vnic_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i[g]),
      .trig_i (trig_q[g]),
      .set_i  (set_mask[g]),
      .clr_i  (clr_mask[g]),
      .pend_o (pend[g])
    );
  end

  vnic_arbiter #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .IDX_W   (SEL_W)
  ) u_arb (
    .req_i   (pend & en_q),
    .prio_i  (prio_flat),
    .valid_o (arb_valid),
    .idx_o   (arb_idx),
    .prio_o  (arb_prio)
  );

  vnic_nest_stack #(
    .DEPTH  (NEST_DEPTH),
    .PRIO_W (PRIO_W),
    .IDX_W  (SEL_W)
  ) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .pop_i       (pop),
    .push_prio_i (arb_prio),
    .push_idx_i  (arb_idx),
    .count_o     (stk_cnt),
    .top_prio_o  (top_prio),
    .top_idx_o   (top_idx)
  );

  // read mux
  always_comb begin
    en_pad = '0;
    en_pad[NUM_SRC-1:0] = en_q;
    mode_word = '0;
    mode_word[PRIO_W-1:0] = prio_q[sel_q];
    mode_word[MODE_TRIG_LSB +: 2] = trig_q[sel_q];
    case (bus_addr_i)
      OFS_SEL:  rd_val = 32'(sel_q);
      OFS_MODE: rd_val = mode_word;
      OFS_VEC:  rd_val = 32'(vec_q[sel_q]);
      OFS_IVR:  rd_val = irq_o ? 32'(vec_q[arb_idx]) : 32'(spur_q);
      OFS_STAT: rd_val = 32'(top_idx);
      OFS_MASK: rd_val = en_pad[32*(int'(sel_q) / 32) +: 32];
      OFS_SPUR: rd_val = 32'(spur_q);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      en_q    <= '0;
      spur_q  <= '0;
      rdata_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        prio_q[i] <= '0;
        trig_q[i] <= TRIG_HIGH;
        vec_q[i]  <= '0;
      end
    end else begin
      if (rd) rdata_q <= rd_val;
      if (wr) begin
        case (bus_addr_i)
          OFS_SEL:  if ({1'b0, bus_wdata_i[SEL_W-1:0]} < SRC_LIM) sel_q <= bus_wdata_i[SEL_W-1:0];
          OFS_MODE: begin
            prio_q[sel_q] <= bus_wdata_i[PRIO_W-1:0];
            trig_q[sel_q] <= bus_wdata_i[MODE_TRIG_LSB +: 2];
          end
          OFS_VEC:  vec_q[sel_q] <= bus_wdata_i[VEC_W-1:0];
          OFS_SPUR: spur_q <= bus_wdata_i[VEC_W-1:0];
          OFS_EN:   en_q <= en_q | sel_hot;
          OFS_DIS:  en_q <= en_q & ~sel_hot;
          default: ;
        endcase
      end
    end
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/vnic_ctrl_chk.sv
module vnic_ctrl_chk #(
  parameter int NEST_DEPTH = 8,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 32,
  localparam int CNT_W = $clog2(NEST_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [7:0]        bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic              irq_o,
  input logic [VEC_W-1:0]  spur_q,
  input logic [CNT_W-1:0]  stk_cnt,
  input logic [PRIO_W-1:0] top_prio
);
  logic rd_ivr, wr_eoi;
  assign rd_ivr = bus_en_i && !bus_we_i && bus_addr_i == 8'h10;
  assign wr_eoi = bus_en_i && bus_we_i && bus_addr_i == 8'h38;

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stk_cnt <= CNT_W'(NEST_DEPTH)); // R12

  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ivr && irq_o) |=> stk_cnt == $past(stk_cnt) + CNT_W'(1)); // R10

  AST_NEST_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ivr && irq_o && stk_cnt != '0) |=> top_prio > $past(top_prio)); // R9

  AST_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ivr && !irq_o) |=> (bus_rdata_o == 32'($past(spur_q)) && stk_cnt == $past(stk_cnt))); // R11

  AST_EOI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eoi && stk_cnt != '0) |=> stk_cnt == $past(stk_cnt) - CNT_W'(1)); // R12
endmodule

bind vnic_ctrl vnic_ctrl_chk #(
  .NEST_DEPTH (NEST_DEPTH),
  .PRIO_W     (PRIO_W),
  .VEC_W      (VEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .spur_q      (spur_q),
  .stk_cnt     (stk_cnt),
  .top_prio    (top_prio)
);

// File: tb/test_vnic_ctrl.sv
module test_vnic_ctrl;
  localparam int NS = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int m_sel, m_spur;
  int m_prio[NS], m_trig[NS], m_vec[NS];
  bit m_en[NS], m_latch[NS], m_prev[NS];
  int stk_p[$];
  int stk_i[$];
  int exp_rd;

  always #2 clk = ~clk;

  vnic_ctrl #(.NUM_SRC(NS)) i_vnic_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .bus_en_i    (bus_en),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit lvl(int i);
    if (m_trig[i] == 0) return src[i];
    if (m_trig[i] == 2) return !src[i];
    return 1'b0;
  endfunction

  // R8 winner search
  function automatic int winner(output int bp);
    int bi = -1;
    bp = -1;
    for (int i = 0; i < NS; i++)
      if ((lvl(i) || m_latch[i]) && m_en[i] && m_prio[i] > bp) begin
        bp = m_prio[i];
        bi = i;
      end
    return bi;
  endfunction

  function automatic bit model_irq();
    int bp;
    int bi = winner(bp);
    return bi >= 0 && (stk_p.size() == 0 || bp > stk_p[$]);
  endfunction

  task automatic model_step();
    int bp;
    int bi = winner(bp);
    bit im = model_irq();
    bit edg[NS];
    bit clrm[NS];
    bit setm[NS];
    for (int i = 0; i < NS; i++) begin
      edg[i] = (m_trig[i] == 1 && src[i] && !m_prev[i]) ||
               (m_trig[i] == 3 && !src[i] && m_prev[i]);
      clrm[i] = 0;
      setm[i] = 0;
    end
    if (bus_en && !bus_we) begin
      case (bus_addr)
        8'h00: exp_rd = m_sel;
        8'h04: exp_rd = m_prio[m_sel] | (m_trig[m_sel] << 5);
        8'h08: exp_rd = m_vec[m_sel];
        8'h10: if (im) begin
                 exp_rd = m_vec[bi];
                 stk_p.push_back(bp);
                 stk_i.push_back(bi);
                 clrm[bi] = 1;
               end else exp_rd = m_spur;
        8'h18: exp_rd = (stk_i.size() != 0) ? stk_i[$] : 0;
        8'h30: begin
                 exp_rd = 0;
                 for (int j = 0; j < 32; j++)
                   if ((m_sel / 32) * 32 + j < NS && m_en[(m_sel / 32) * 32 + j]) exp_rd |= (1 << j);
               end
        8'h3C: exp_rd = m_spur;
        default: exp_rd = 0;
      endcase
    end
    if (bus_en && bus_we) begin
      case (bus_addr)
        8'h00: if ((bus_wdata & 63) < NS) m_sel = bus_wdata & 63;
        8'h04: begin m_prio[m_sel] = bus_wdata & 7; m_trig[m_sel] = (bus_wdata >> 5) & 3; end
        8'h08: m_vec[m_sel] = bus_wdata;
        8'h3C: m_spur = bus_wdata;
        8'h40: m_en[m_sel] = 1;
        8'h44: m_en[m_sel] = 0;
        8'h48: clrm[m_sel] = 1;
        8'h4C: setm[m_sel] = 1;
        8'h38: if (stk_p.size() != 0) begin void'(stk_p.pop_back()); void'(stk_i.pop_back()); end
        default: ;
      endcase
    end
    for (int i = 0; i < NS; i++) begin
      m_latch[i] = (m_latch[i] && !clrm[i]) || edg[i] || setm[i];
      m_prev[i]  = src[i];
    end
  endtask

  // one clock: compare the line, advance model, move to next falling edge
  task automatic cyc();
    #1;
    check("R9 irq line", int'(irq), int'(model_irq()));
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, int d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, string req);
    bus_en = 1; bus_we = 0; bus_addr = a;
    cyc();
    bus_en = 0;
    check(req, bus_rdata, exp_rd);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic cfg(int s, int prio, int trig, int vec);
    wr(8'h00, s);
    wr(8'h04, prio | (trig << 5));
    wr(8'h08, vec);
    wr(8'h40, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_sel = 0; m_spur = 0;
    for (int i = 0; i < NS; i++) begin
      m_prio[i] = 0; m_trig[i] = 0; m_vec[i] = 0; m_en[i] = 0; m_latch[i] = 0; m_prev[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    check("R13 rdata at reset", bus_rdata, 0);
    check("R13 irq at reset", int'(irq), 0);
    rd(8'h30, "R13 mask");
    rd(8'h18, "R13 status");
    rd(8'h04, "R13 mode");
    rd(8'h3C, "R13 spurious");
    rd(8'h20, "R13 unmapped");
    // R1 select and its range limit
    wr(8'h00, 5); wr(8'h00, 45); rd(8'h00, "R1 out-of-range select ignored");
    wr(8'h00, 39); rd(8'h00, "R1 top select");
    // R2 R3 programming
    cfg(3, 2, 0, 32'h300);
    cfg(35, 5, 1, 32'h3500);
    cfg(10, 1, 2, 32'h1000);
    cfg(11, 4, 3, 32'h1100);
    wr(8'h00, 35); rd(8'h04, "R2 mode read"); rd(8'h08, "R3 vector read");
    rd(8'h30, "R4 upper bank mask");
    wr(8'h00, 3); rd(8'h30, "R4 lower bank mask");
    // level-low source 10 is pending now
    rd(8'h10, "R10 ack level-low R5");
    rd(8'h18, "R10 status after ack");
    src[10] = 1; idle(1);
    wr(8'h38, 0);
    // R5 level-high
    src[3] = 1; idle(1);
    rd(8'h10, "R10 ack level-high R5");
    src[3] = 0; idle(1); wr(8'h38, 0);
    // R6 rising edge pulse
    src[35] = 1; idle(1); src[35] = 0; idle(2);
    rd(8'h10, "R6 rising edge vector");
    wr(8'h38, 0); idle(1);
    // R6 falling edge, then R7 clear
    src[11] = 1; idle(1); src[11] = 0; idle(2);
    wr(8'h00, 11); wr(8'h48, 0); idle(1);
    rd(8'h10, "R7 clear removes latch, spurious R11");
    // R7 set and R8 tie break
    cfg(20, 4, 1, 32'h2000);
    wr(8'h4C, 0); wr(8'h00, 11); wr(8'h4C, 0);
    rd(8'h10, "R8 tie goes to lower number");
    rd(8'h18, "R8 status");
    wr(8'h38, 0);
    rd(8'h10, "R7 remaining set source");
    wr(8'h38, 0);
    // R4 disable blocks
    wr(8'h00, 35); wr(8'h44, 0); wr(8'h4C, 0); idle(1);
    rd(8'h30, "R4 disable bank1");
    wr(8'h3C, 32'hDEAD);
    rd(8'h10, "R11 spurious with disabled source");
    wr(8'h48, 0);
    // R12 eight-level nesting
    for (int p = 0; p < 8; p++) begin
      cfg(24 + p, p, 1, 32'h4000 + p);
      wr(8'h4C, 0);
      rd(8'h10, "R10 nested ack");
    end
    rd(8'h18, "R12 status at full depth");
    wr(8'h00, 12); wr(8'h04, 7); wr(8'h40, 0); wr(8'h4C, 0);
    rd(8'h10, "R11 equal priority cannot nest");
    for (int k = 0; k < 9; k++) begin
      wr(8'h38, 0);
      rd(8'h18, "R12 unwind status");
    end
    rd(8'h10, "R12 released line acks pending");
    wr(8'h38, 0); wr(8'h38, 0);
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule